// File: doc/BRIEF.md
# Dual-Channel Audio DMA Address Sequencer

This block steps through memory buffers for two audio streams, one that records (capture) and one that plays out (playback). Software programs each channel through a 32-bit register port. It writes a current buffer (start address and byte count) and, while that buffer is still running, an optional follow-on buffer. For each enabled channel the block asserts a word-transfer request that carries the current address. Each acknowledge moves the address on by one word and reduces the remaining byte count by the same amount.

When a buffer runs out, the channel either moves on to the follow-on buffer, if one was written since the last switch, or it stops. Both outcomes raise status flags. Software clears these flags by writing 1 to them, so an ordinary control write does not discard events that are still pending. A single interrupt output combines the flags with per-source enables and a global enable. Strobes from the surrounding datapath report lost capture data and playback underrun. A self-clearing control bit puts the whole block back into its reset state.

Top module: `aud_dma_seq`

## Requirements
- R1: After reset every register reads 0, both request outputs are low, and `irq` and `codec_pdn` are low.
- R2: Byte offsets 16/20/24/28 hold the capture current address, current count, next address and next count. Offsets 32/36/40/44 hold the same four for playback. Each reads back the value written. The CSR is at offset 0. Offsets 4, 8 and 12 read 0.
- R3: A write to a channel's next-address register sets that channel's dirty flag (CSR bit 10 capture, bit 13 playback). Switching to the next buffer clears the flag.
- R4: A channel requests exactly when its go bit (CSR bit 2 capture, bit 3 playback) is 1, its pause bit is 0 and its current count is nonzero. The request presents the current address. Each acknowledged request adds 4 to the address and subtracts 4 from the count.
- R5: When the acknowledge that empties the count arrives with the dirty flag set, the next address and count become current. The channel's buffer interrupt is then set (bit 21 capture, bit 22 playback).
- R6: When that acknowledge arrives with the dirty flag clear, the count stays 0 and the channel stops. Capture sets bit 9. Playback sets bits 15 and 14. Bit 14 clears when software writes the playback current count.
- R7: With the pause bit set (bit 6 capture, bit 7 playback), no request is made and the channel's address and count hold, even while acknowledge is high. After the pause bit clears, transfers continue from the held address.
- R8: Bits 22, 21, 20, 15 and 9 are cleared by writing 1. Writing 0 leaves them unchanged.
- R9: Bit 23 and `irq` are 1 exactly when bit 19 is 1 and at least one of the pairs 22/18, 21/17, 20/16, 15/12, 9/8 has both bits set.
- R10: A `cap_drop` pulse sets bits 11 and 20. A `play_underrun` pulse sets bit 20. Bit 11 stays set until the block is reset.
- R11: Writes to bits 23, 14, 13, 11 and 10 have no effect.
- R12: Writing 1 to bit 0 returns every register and all channel state to 0 one cycle later. Bit 0 then reads 0.
- R13: CSR bit 5 is read/write and drives `codec_pdn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_req | output | 1 | Capture word transfer request |
| cap_addr | output | 32 | Capture current address |
| cap_ack | input | 1 | Capture transfer accepted this cycle |
| cap_drop | input | 1 | Capture data lost strobe |
| play_req | output | 1 | Playback word transfer request |
| play_addr | output | 32 | Playback current address |
| play_ack | input | 1 | Playback transfer accepted this cycle |
| play_underrun | input | 1 | Playback underrun strobe |
| codec_pdn | output | 1 | Codec power-down/reset control |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong current address or count shows on the request address at the very next acknowledged transfer. It also shows as a switch to the next buffer, or a stop, one transfer early or late. A lost or stuck dirty flag turns an expected switch into a stop, or the reverse, and the wrong status bit appears the cycle after the final acknowledge. A flag register that clears on a 0 write, or ignores a 1 write, changes `irq` on the cycle after the CSR write.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  localparam int NCH     = 2;
  localparam int CH_CAP  = 0;
  localparam int CH_PLAY = 1;

  // control/status bit positions
  localparam int B_PEND   = 23;
  localparam int B_PINT   = 22;
  localparam int B_CINT   = 21;
  localparam int B_EINT   = 20;
  localparam int B_GIE    = 19;
  localparam int B_PIE    = 18;
  localparam int B_CIE    = 17;
  localparam int B_EIE    = 16;
  localparam int B_PMINT  = 15;
  localparam int B_PEMPTY = 14;
  localparam int B_PDIRTY = 13;
  localparam int B_PMIE   = 12;
  localparam int B_CDROP  = 11;
  localparam int B_CDIRTY = 10;
  localparam int B_CMINT  = 9;
  localparam int B_CMIE   = 8;
  localparam int B_PPAUSE = 7;
  localparam int B_CPAUSE = 6;
  localparam int B_PDN    = 5;
  localparam int B_PGO    = 3;
  localparam int B_CGO    = 2;
  localparam int B_SRST   = 0;

  // register window layout
  localparam int OFS_CSR     = 0;
  localparam int OFS_CH_BASE = 16;
  localparam int OFS_CH_SPAN = 16;
  localparam int NSLOT       = 4;
  localparam int SL_CUR_A    = 0;
  localparam int SL_CUR_C    = 1;
  localparam int SL_NXT_A    = 2;
  localparam int SL_NXT_C    = 3;

  typedef struct packed {
    logic chain;
    logic stop;
  } ch_evt_t;
endpackage

// File: rtl/aud_dma_chan.sv
module aud_dma_chan
  import aud_dma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             ack,
  input  logic [NSLOT-1:0] wr_sel,
  input  logic [DW-1:0]    wdata,
  output logic             req,
  output logic [DW-1:0]    cur_addr_o,
  output logic [DW-1:0]    cur_cnt_o,
  output logic [DW-1:0]    nxt_addr_o,
  output logic [DW-1:0]    nxt_cnt_o,
  output logic             dirty_o,
  output ch_evt_t          evt_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic [DW-1:0] ca_q, ca_d, cc_q, cc_d, na_q, na_d, nc_q, nc_d;
  logic          dt_q, dt_d;
  logic          xfer, last, upd;

  assign req  = run && (cc_q != '0);
  assign xfer = req && ack;
  assign last = xfer && (cc_q <= STEP_V);
  assign upd  = clr | xfer | (|wr_sel);

  always_comb begin
    ca_d  = ca_q;
    cc_d  = cc_q;
    na_d  = na_q;
    nc_d  = nc_q;
    dt_d  = dt_q;
    evt_o = '0;
    if (xfer) begin
      if (last && dt_q) begin
        ca_d        = na_q;
        cc_d        = nc_q;
        dt_d        = 1'b0;
        evt_o.chain = 1'b1;
      end else if (last) begin
        ca_d       = ca_q + STEP_V;
        cc_d       = '0;
        evt_o.stop = 1'b1;
      end else begin
        ca_d = ca_q + STEP_V;
        cc_d = cc_q - STEP_V;
      end
    end
    // software writes take precedence over the transfer update
    if (wr_sel[SL_CUR_A]) ca_d = wdata;
    if (wr_sel[SL_CUR_C]) cc_d = wdata;
    if (wr_sel[SL_NXT_C]) nc_d = wdata;
    if (wr_sel[SL_NXT_A]) begin
      na_d = wdata;
      dt_d = 1'b1;
    end
    if (clr) begin
      ca_d  = '0;
      cc_d  = '0;
      na_d  = '0;
      nc_d  = '0;
      dt_d  = 1'b0;
      evt_o = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cc_q <= '0;
      na_q <= '0;
      nc_q <= '0;
      dt_q <= 1'b0;
    end else if (upd) begin
      ca_q <= ca_d;
      cc_q <= cc_d;
      na_q <= na_d;
      nc_q <= nc_d;
      dt_q <= dt_d;
    end
  end

  assign cur_addr_o = ca_q;
  assign cur_cnt_o  = cc_q;
  assign nxt_addr_o = na_q;
  assign nxt_cnt_o  = nc_q;
  assign dirty_o    = dt_q;
endmodule

// File: rtl/aud_dma_irq.sv
module aud_dma_irq #(
  parameter int N = 5
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  input  logic         gie,
  output logic         pend
);
  assign pend = gie && (|(flags & en));
endmodule

// File: rtl/aud_dma_csr.sv
module aud_dma_csr
  import aud_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  input  ch_evt_t        cap_evt,
  input  ch_evt_t        play_evt,
  input  logic           cap_drop,
  input  logic           play_underrun,
  input  logic           play_cnt_wr,
  input  logic           cap_dirty,
  input  logic           play_dirty,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] go,
  output logic [NCH-1:0] pause,
  output logic           pdn,
  output logic           srst,
  output logic           irq
);
  localparam int NFL = 5;

  // flag / enable order: {play buf, cap buf, error, play empty, cap empty}
  logic [NFL-1:0] fl_q, fl_d, en_q, en_d, w_fl, w_en, set_fl;
  logic [NCH-1:0] go_q, go_d, pa_q, pa_d;
  logic           gie_q, gie_d, pe_q, pe_d, cd_q, cd_d, pdn_q, pdn_d, sr_q, sr_d;
  logic           pend, upd;
  logic           unused_bits;

  assign w_fl   = {wdata[B_PINT], wdata[B_CINT], wdata[B_EINT], wdata[B_PMINT], wdata[B_CMINT]};
  assign w_en   = {wdata[B_PIE], wdata[B_CIE], wdata[B_EIE], wdata[B_PMIE], wdata[B_CMIE]};
  assign set_fl = {play_evt.chain, cap_evt.chain, cap_drop | play_underrun,
                   play_evt.stop, cap_evt.stop};
  assign unused_bits = ^{wdata[DW-1:24], wdata[B_PEND], wdata[B_PEMPTY], wdata[B_PDIRTY],
                         wdata[B_CDROP], wdata[B_CDIRTY], wdata[4], wdata[1]};

  assign upd = sr_q | wr | (|set_fl) | play_cnt_wr;

  always_comb begin
    fl_d  = (fl_q & ~({NFL{wr}} & w_fl)) | set_fl;
    en_d  = en_q;
    gie_d = gie_q;
    go_d  = go_q;
    pa_d  = pa_q;
    pdn_d = pdn_q;
    pe_d  = (pe_q & ~play_cnt_wr) | play_evt.stop;
    cd_d  = cd_q | cap_drop;
    sr_d  = wr & wdata[B_SRST];
    if (wr) begin
      en_d  = w_en;
      gie_d = wdata[B_GIE];
      go_d  = {wdata[B_PGO], wdata[B_CGO]};
      pa_d  = {wdata[B_PPAUSE], wdata[B_CPAUSE]};
      pdn_d = wdata[B_PDN];
    end
    if (sr_q) begin
      fl_d  = '0;
      en_d  = '0;
      gie_d = 1'b0;
      go_d  = '0;
      pa_d  = '0;
      pdn_d = 1'b0;
      pe_d  = 1'b0;
      cd_d  = 1'b0;
      sr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      en_q  <= '0;
      gie_q <= 1'b0;
      go_q  <= '0;
      pa_q  <= '0;
      pdn_q <= 1'b0;
      pe_q  <= 1'b0;
      cd_q  <= 1'b0;
      sr_q  <= 1'b0;
    end else if (upd) begin
      fl_q  <= fl_d;
      en_q  <= en_d;
      gie_q <= gie_d;
      go_q  <= go_d;
      pa_q  <= pa_d;
      pdn_q <= pdn_d;
      pe_q  <= pe_d;
      cd_q  <= cd_d;
      sr_q  <= sr_d;
    end
  end

  aud_dma_irq #(.N(NFL)) u_irq (
    .flags (fl_q),
    .en    (en_q),
    .gie   (gie_q),
    .pend  (pend)
  );

  always_comb begin
    rdata           = '0;
    rdata[B_PEND]   = pend;
    rdata[B_PINT]   = fl_q[4];
    rdata[B_CINT]   = fl_q[3];
    rdata[B_EINT]   = fl_q[2];
    rdata[B_PMINT]  = fl_q[1];
    rdata[B_CMINT]  = fl_q[0];
    rdata[B_PIE]    = en_q[4];
    rdata[B_CIE]    = en_q[3];
    rdata[B_EIE]    = en_q[2];
    rdata[B_PMIE]   = en_q[1];
    rdata[B_CMIE]   = en_q[0];
    rdata[B_GIE]    = gie_q;
    rdata[B_PEMPTY] = pe_q;
    rdata[B_PDIRTY] = play_dirty;
    rdata[B_CDROP]  = cd_q;
    rdata[B_CDIRTY] = cap_dirty;
    rdata[B_PPAUSE] = pa_q[CH_PLAY];
    rdata[B_CPAUSE] = pa_q[CH_CAP];
    rdata[B_PDN]    = pdn_q;
    rdata[B_PGO]    = go_q[CH_PLAY];
    rdata[B_CGO]    = go_q[CH_CAP];
    rdata[B_SRST]   = sr_q;
  end

  assign go    = go_q;
  assign pause = pa_q;
  assign pdn   = pdn_q;
  assign srst  = sr_q;
  assign irq   = pend;
endmodule

// File: rtl/aud_dma_seq.sv
module aud_dma_seq
  import aud_dma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int RAW  = 6,
  parameter int STEP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           cap_req,
  output logic [DW-1:0]  cap_addr,
  input  logic           cap_ack,
  input  logic           cap_drop,
  output logic           play_req,
  output logic [DW-1:0]  play_addr,
  input  logic           play_ack,
  input  logic           play_underrun,
  output logic           codec_pdn,
  output logic           irq
);
  logic [1:0]     rst_sync;
  logic           rst_ns;
  logic [DW-1:0]  csr_rd;
  logic [NCH-1:0] go_v, pause_v, req_v, ack_v, dirty_v;
  logic [DW-1:0]  ch_ca [NCH];
  logic [DW-1:0]  ch_cc [NCH];
  logic [DW-1:0]  ch_na [NCH];
  logic [DW-1:0]  ch_nc [NCH];
  ch_evt_t        evt_v [NCH];
  logic           srst, wr_csr, play_cnt_wr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  assign ack_v       = {play_ack, cap_ack};
  assign wr_csr      = reg_wr && (reg_addr == RAW'(OFS_CSR));
  assign play_cnt_wr = reg_wr &&
    (reg_addr == RAW'(OFS_CH_BASE + CH_PLAY*OFS_CH_SPAN + SL_CUR_C*4));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [NSLOT-1:0] sel;
    for (genvar s = 0; s < NSLOT; s++) begin : g_sl
      assign sel[s] = reg_wr && (reg_addr == RAW'(OFS_CH_BASE + g*OFS_CH_SPAN + s*4));
    end
    aud_dma_chan #(.DW(DW), .STEP(STEP)) u_chan (
      .clk        (clk),
      .rst_n      (rst_ns),
      .clr        (srst),
      .run        (go_v[g] && !pause_v[g]),
      .ack        (ack_v[g]),
      .wr_sel     (sel),
      .wdata      (reg_wdata),
      .req        (req_v[g]),
      .cur_addr_o (ch_ca[g]),
      .cur_cnt_o  (ch_cc[g]),
      .nxt_addr_o (ch_na[g]),
      .nxt_cnt_o  (ch_nc[g]),
      .dirty_o    (dirty_v[g]),
      .evt_o      (evt_v[g])
    );
  end

  aud_dma_csr #(.DW(DW)) u_csr (
    .clk           (clk),
    .rst_n         (rst_ns),
    .wr            (wr_csr),
    .wdata         (reg_wdata),
    .cap_evt       (evt_v[CH_CAP]),
    .play_evt      (evt_v[CH_PLAY]),
    .cap_drop      (cap_drop),
    .play_underrun (play_underrun),
    .play_cnt_wr   (play_cnt_wr),
    .cap_dirty     (dirty_v[CH_CAP]),
    .play_dirty    (dirty_v[CH_PLAY]),
    .rdata         (csr_rd),
    .go            (go_v),
    .pause         (pause_v),
    .pdn           (codec_pdn),
    .srst          (srst),
    .irq           (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(OFS_CSR)) reg_rdata = csr_rd;
    for (int g = 0; g < NCH; g++) begin
      if (reg_addr == RAW'(OFS_CH_BASE + g*OFS_CH_SPAN + SL_CUR_A*4)) reg_rdata = ch_ca[g];
      if (reg_addr == RAW'(OFS_CH_BASE + g*OFS_CH_SPAN + SL_CUR_C*4)) reg_rdata = ch_cc[g];
      if (reg_addr == RAW'(OFS_CH_BASE + g*OFS_CH_SPAN + SL_NXT_A*4)) reg_rdata = ch_na[g];
      if (reg_addr == RAW'(OFS_CH_BASE + g*OFS_CH_SPAN + SL_NXT_C*4)) reg_rdata = ch_nc[g];
    end
  end

  assign cap_req   = req_v[CH_CAP];
  assign cap_addr  = ch_ca[CH_CAP];
  assign play_req  = req_v[CH_PLAY];
  assign play_addr = ch_ca[CH_PLAY];
endmodule

// File: rtl/aud_dma_seq_chk.sv
module aud_dma_seq_chk #(
  parameter int DW   = 32,
  parameter int RAW  = 6,
  parameter int STEP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic           cap_req,
  input logic           cap_ack,
  input logic [DW-1:0]  cap_addr,
  input logic [DW-1:0]  cap_cnt,
  input logic           cap_go,
  input logic           cap_pause,
  input logic           srst,
  input logic           cap_chain,
  input logic           irq,
  input logic [DW-1:0]  csr_rd
);
  // R4: request only while running
  p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |-> (cap_go && !cap_pause));

  // R4: mid-buffer transfer steps the address by one word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && cap_ack && (cap_cnt > DW'(STEP)) && !srst &&
     !(reg_wr && reg_addr == RAW'(16)))
    |=> (cap_addr == $past(cap_addr) + DW'(STEP)));

  // R7: paused channel keeps its position
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pause && !srst && !(reg_wr && reg_addr == RAW'(16)))
    |=> $stable(cap_addr));

  // R3: next-address write marks the channel dirty
  p_dirty_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RAW'(24) && !srst) |=> csr_rd[10]);

  // R8: writing 1 clears the capture buffer flag
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RAW'(0) && reg_wdata[21] && !srst && !cap_chain)
    |=> !csr_rd[21]);

  // R9: interrupt requires the global enable
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr_rd[19]);

  // R12: self reset leaves the CSR at zero
  p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (csr_rd == '0));
endmodule

bind aud_dma_seq aud_dma_seq_chk #(.DW(DW), .RAW(RAW), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cap_req   (cap_req),
  .cap_ack   (cap_ack),
  .cap_addr  (cap_addr),
  .cap_cnt   (ch_cc[0]),
  .cap_go    (go_v[0]),
  .cap_pause (pause_v[0]),
  .srst      (srst),
  .cap_chain (evt_v[0].chain),
  .irq       (irq),
  .csr_rd    (csr_rd)
);

// File: tb/aud_dma_seq_tb_top.sv
module aud_dma_seq_tb_top;
  localparam int TCLK = 20;

  localparam logic [31:0] GIE = 32'h1 << 19, PIE = 32'h1 << 18, CIE = 32'h1 << 17;
  localparam logic [31:0] EIE = 32'h1 << 16, PMIE = 32'h1 << 12, CMIE = 32'h1 << 8;
  localparam logic [31:0] PPAU = 32'h1 << 7, PDN = 32'h1 << 5;
  localparam logic [31:0] PGO = 32'h1 << 3, CGO = 32'h1 << 2;
  localparam logic [31:0] F23 = 32'h1 << 23, F22 = 32'h1 << 22, F21 = 32'h1 << 21;
  localparam logic [31:0] F20 = 32'h1 << 20, F15 = 32'h1 << 15, F14 = 32'h1 << 14;
  localparam logic [31:0] F13 = 32'h1 << 13, F11 = 32'h1 << 11, F10 = 32'h1 << 10;
  localparam logic [31:0] F9 = 32'h1 << 9;

  logic        clk, rst_n, reg_wr, cap_ack, cap_drop, play_ack, play_underrun;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, cap_addr, play_addr;
  logic        cap_req, play_req, codec_pdn, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_cap[$];
  logic [31:0] exp_play[$];

  aud_dma_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_req(cap_req),
    .cap_addr(cap_addr), .cap_ack(cap_ack), .cap_drop(cap_drop),
    .play_req(play_req), .play_addr(play_addr), .play_ack(play_ack),
    .play_underrun(play_underrun), .codec_pdn(codec_pdn), .irq(irq)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pin(input logic got, input logic exp, input string tag);
    @(negedge clk);
    #5;
    chk(tag, {31'b0, got}, {31'b0, exp});
  endtask

  // driver side of the scoreboard
  task automatic expect_xfer(input int ch, input logic [31:0] a);
    if (ch == 0) exp_cap.push_back(a);
    else         exp_play.push_back(a);
  endtask

  // monitor: compare each accepted transfer with the queue front
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && cap_req && cap_ack) begin
        if (exp_cap.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4: capture transfer at %h, expected none", cap_addr);
        end else chk("R4 capture transfer address", cap_addr, exp_cap.pop_front());
      end
      if (rst_n && play_req && play_ack) begin
        if (exp_play.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4: playback transfer at %h, expected none", play_addr);
        end else chk("R4 playback transfer address", play_addr, exp_play.pop_front());
      end
    end
  end

  initial begin
    #(TCLK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [31:0] c0, c1, v;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cap_ack = 1'b0; cap_drop = 1'b0; play_ack = 1'b0; play_underrun = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 32'h0, "R1 csr after reset");
    rd(32, 32'h0, "R1 playback address after reset");
    pin(cap_req, 1'b0, "R1 cap_req");
    pin(play_req, 1'b0, "R1 play_req");
    pin(irq, 1'b0, "R1 irq");
    pin(codec_pdn, 1'b0, "R1 codec_pdn");

    // R2 register map, R3 dirty on next-address write
    wr(16, 32'h1000); wr(20, 32'd8); wr(24, 32'h2000); wr(28, 32'd4);
    rd(16, 32'h1000, "R2 capture current address");
    rd(20, 32'd8, "R2 capture current count");
    rd(24, 32'h2000, "R2 capture next address");
    rd(28, 32'd4, "R2 capture next count");
    rd(4, 32'h0, "R2 reserved 4");
    rd(8, 32'h0, "R2 reserved 8");
    rd(12, 32'h0, "R2 reserved 12");
    rd(0, F10, "R3 capture dirty set");
    pin(cap_req, 1'b0, "R4 no request without go");

    // R4/R5/R6 capture run with one chain then stop
    c0 = GIE | CIE | CMIE | CGO;
    expect_xfer(0, 32'h1000); expect_xfer(0, 32'h1004); expect_xfer(0, 32'h2000);
    wr(0, c0);
    pin(cap_req, 1'b1, "R4 request with go");
    @(negedge clk); cap_ack = 1'b1;
    repeat (5) @(negedge clk);
    cap_ack = 1'b0;
    chk("R5 capture transfers consumed", exp_cap.size(), 0);
    pin(cap_req, 1'b0, "R6 capture stopped");
    rd(0, c0 | F21 | F9 | F23, "R5 R6 capture flags, dirty clear");
    rd(16, 32'h2004, "R4 capture address after run");
    rd(20, 32'h0, "R6 capture count zero");
    pin(irq, 1'b1, "R9 irq with enabled flags");

    // R8 write-1-to-clear, R11 read-only bits
    wr(0, c0);
    rd(0, c0 | F21 | F9 | F23, "R8 zero write keeps flags");
    wr(0, c0 | F21);
    rd(0, c0 | F9 | F23, "R8 clear capture buffer flag");
    wr(0, c0 | F9);
    rd(0, c0, "R8 clear capture empty flag");
    pin(irq, 1'b0, "R9 irq low after clear");
    wr(0, c0 | F23 | F14 | F13 | F11 | F10);
    rd(0, c0, "R11 read-only bits ignore writes");

    // R7 pause on playback
    c1 = c0 | PIE | PMIE | PGO | PPAU;
    wr(32, 32'h3000); wr(36, 32'd8);
    wr(0, c1);
    @(negedge clk); play_ack = 1'b1;
    repeat (4) @(negedge clk);
    pin(play_req, 1'b0, "R7 no request while paused");
    rd(32, 32'h3000, "R7 address held while paused");
    rd(36, 32'd8, "R7 count held while paused");
    expect_xfer(1, 32'h3000); expect_xfer(1, 32'h3004);
    c1 = c1 & ~PPAU;
    wr(0, c1);
    repeat (4) @(negedge clk);
    play_ack = 1'b0;
    chk("R7 playback resumed transfers consumed", exp_play.size(), 0);
    rd(0, c1 | F15 | F14 | F23, "R6 playback stop flags");
    rd(32, 32'h3008, "R7 playback address after resume");

    // R6 empty status clears on count write
    wr(36, 32'h0);
    rd(0, c1 | F15 | F23, "R6 empty cleared by count write");
    wr(0, c1 | F15);
    rd(0, c1, "R8 clear playback empty flag");

    // R10 strobes, R9 gating
    @(negedge clk); cap_drop = 1'b1;
    @(negedge clk); cap_drop = 1'b0;
    rd(0, c1 | F11 | F20, "R10 drop sets 11 and 20");
    pin(irq, 1'b0, "R9 error flag masked");
    wr(0, c1 | EIE);
    rd(0, c1 | EIE | F11 | F20 | F23, "R9 error enabled");
    pin(irq, 1'b1, "R9 irq on error");
    wr(0, (c1 | EIE) & ~GIE);
    rd(0, ((c1 | EIE) & ~GIE) | F11 | F20, "R9 global enable off");
    pin(irq, 1'b0, "R9 irq off without global enable");
    wr(0, c1 | EIE | F20);
    rd(0, c1 | EIE | F11, "R10 error cleared, drop sticky");
    @(negedge clk); play_underrun = 1'b1;
    @(negedge clk); play_underrun = 1'b0;
    rd(0, c1 | EIE | F11 | F20 | F23, "R10 underrun sets 20");

    // R13 codec power-down
    v = c1 | EIE | PDN;
    wr(0, v);
    pin(codec_pdn, 1'b1, "R13 codec_pdn follows bit 5");
    rd(0, v | F11 | F20 | F23, "R13 bit 5 reads back");

    // R3/R5 playback chain
    wr(40, 32'h5000);
    rd(0, v | F11 | F20 | F23 | F13, "R3 playback dirty set");
    wr(44, 32'd4); wr(32, 32'h4000);
    expect_xfer(1, 32'h4000); expect_xfer(1, 32'h5000);
    @(negedge clk); play_ack = 1'b1;
    wr(36, 32'd4);
    repeat (4) @(negedge clk);
    play_ack = 1'b0;
    chk("R5 playback chain transfers consumed", exp_play.size(), 0);
    rd(0, v | F11 | F20 | F23 | F22 | F15 | F14, "R5 playback chain flags");
    rd(32, 32'h5004, "R5 playback address after chain");

    // R12 self reset
    wr(0, 32'h1);
    rd(0, 32'h0, "R12 csr cleared");
    rd(32, 32'h0, "R12 playback address cleared");
    rd(40, 32'h0, "R12 playback next address cleared");
    rd(24, 32'h0, "R12 capture next address cleared");
    pin(irq, 1'b0, "R12 irq cleared");
    pin(codec_pdn, 1'b0, "R12 codec_pdn cleared");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule